// File: doc/BRIEF.md
# Exception entry sequencer

This block performs the architectural state change that happens when a core takes a trap. A trap can be a synchronous exception, an external interrupt, a translation refill miss or a debug breakpoint. The caller holds the take strobe high for one cycle. With it, the caller presents the raw cause code, any bus-failure indication, the refill flag, the winning interrupt vector index, the faulting PC and instruction word, and the current privilege, interrupt-enable and debug-mode bits.

In a single edge, the block loads one of three save sets: normal, refill or debug. It also records the bad address and the bad instruction where the cause calls for them. It forces the core to privilege 0 with interrupts masked, and it computes the new PC. The new PC uses a programmable power-of-two vector spacing. The cycle after the strobe, `done` is high alongside the new PC. A cause code the block does not support raises `err` for that cycle instead, and no state changes.

A three-state controller drives the handshake:
- `ST_IDLE` waits.
- `ST_ENTERED` marks an accepted entry and drives `done`.
- `ST_FAULT` marks a rejected cause and drives `err`.

From every state, the transitions are the same:
- *accept* goes to `ST_ENTERED` when `take` carries a supported cause.
- *reject* goes to `ST_FAULT` when `take` carries an unsupported cause.
- *rest* goes to `ST_IDLE` when `take` is low.

After reset, the block also drives the reset PC and the reset mode fields.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset:
  - `pc_out` is 0x1C000000.
  - Privilege is 0 and interrupt enable is 0.
  - Direct addressing is 1 and paging is 0.
  - Both memory-type fields read 1.
  - `done` and `err` are 0.
- R2: Every accepted entry pulses `done` in the cycle after `take` and presents the new PC in that same cycle. The entry also sets `mode_plv` to 0 and clears `mode_ie`.
- R3: On the normal path, the entry updates three things:
  - `prev_plv` and `prev_ie` receive the incoming privilege and enable.
  - `ret_addr` receives the PC.
  - `ecode` receives the effective cause.
- R4: The refill path applies when `refill` is set and the entry is not a debug entry. It updates the following, and the normal save set is left unchanged:
  - `rf_prev_plv` and `rf_prev_ie` receive the incoming privilege and enable.
  - Direct addressing is set to 1 and paging is cleared.
  - `rf_ret` receives PC bits [AW-1:2].
  - For non-interrupt causes, the new PC is `tlbrentry`.
- R5: The vector spacing is 0 when `vs` is 0 and 2^(vs+2) bytes otherwise. A normal non-interrupt entry goes to `eentry` + cause × spacing.
- R6: An interrupt is code 0 and it is not a debug entry. It goes to `eentry` + (64 + `vec_idx`) × spacing.
- R7: A breakpoint is code 10. It takes the debug path with the following effects:
  - `dbg_bkpt` is set.
  - `dbg_code` is set to 0xC.
  - `dbg_ret` receives the PC.
  - `dbg_flag` is set.
  - The new PC is `eentry` + 0x480.
- R8: An interrupt taken while `cur_dst` is 1 takes the debug path. It sets `dbg_intr` in place of the breakpoint bits, and otherwise behaves as in R7.
- R9: Six codes write the PC into `badv`: 11, 12, 13, 14, 15 and 16. Other codes leave `badv` unchanged.
- R10: `badi` receives `cur_insn` for every accepted cause except code 0 (interrupt) and code 3 (fetch page invalid). For those two codes, `badi` is unchanged.
- R11: When `bus_fail` is 1, the raw code is ignored. The effective cause is 8 when `bus_fetch` is 1 and 9 otherwise.
- R12: The supported codes are 0 to 16. A `take` with any other code does the following:
  - `err` is 1 in the next cycle.
  - `done` stays 0.
  - `pc_out` and every save register remain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take | input | 1 | One-cycle trap strobe |
| code | input | 6 | Raw cause code |
| bus_fail | input | 1 | Trap caused by a failed bus transaction |
| bus_fetch | input | 1 | Failed transaction was an instruction fetch |
| refill | input | 1 | Trap is a translation refill |
| vec_idx | input | VW | Highest pending enabled interrupt line |
| cur_pc | input | AW | PC of the trapping instruction |
| cur_insn | input | IW | Trapping instruction word |
| cur_plv | input | 2 | Current privilege level |
| cur_ie | input | 1 | Current global interrupt enable |
| cur_dst | input | 1 | Core is in debug mode |
| eentry | input | AW | Exception entry base |
| tlbrentry | input | AW | Refill entry address |
| vs | input | 3 | Vector spacing exponent |
| pc_out | output | AW | New PC |
| done | output | 1 | Entry accepted, PC valid |
| err | output | 1 | Unsupported cause rejected |
| mode_plv | output | 2 | Current privilege after entry |
| mode_ie | output | 1 | Global interrupt enable after entry |
| mode_da | output | 1 | Direct-address mode |
| mode_pg | output | 1 | Paging enable |
| mode_datf | output | 2 | Direct-access fetch memory type |
| mode_datm | output | 2 | Direct-access data memory type |
| prev_plv | output | 2 | Saved privilege, normal path |
| prev_ie | output | 1 | Saved enable, normal path |
| ret_addr | output | AW | Return address, normal path |
| ecode | output | 6 | Recorded cause, normal path |
| badv | output | AW | Bad virtual address |
| badi | output | IW | Bad instruction word |
| rf_prev_plv | output | 2 | Saved privilege, refill path |
| rf_prev_ie | output | 1 | Saved enable, refill path |
| rf_ret | output | AW-2 | Refill return word address |
| dbg_flag | output | 1 | Debug mode entered |
| dbg_bkpt | output | 1 | Debug entry caused by breakpoint |
| dbg_intr | output | 1 | Debug entry caused by interrupt |
| dbg_code | output | 6 | Debug cause code |
| dbg_ret | output | AW | Debug return address |

## Verification
The properties assume three things about the caller:
- `take` is a single-cycle strobe, and the qualifying inputs are valid with it.
- A `done` or `err` cycle reflects only the strobe from the preceding cycle.
- `bus_fail` is low whenever a specific raw code is assumed.

The stimulus meets these assumptions. It raises `take` for exactly one cycle, with all fields set up half a cycle earlier, and it idles for at least one cycle between traps. Each vector uses a fixed pair of entry bases, so the expected targets can be worked out from the spacing rule alone.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int CW = 6;

    localparam logic [CW-1:0] EC_INT  = 6'd0;
    localparam logic [CW-1:0] EC_LDPG = 6'd1;
    localparam logic [CW-1:0] EC_STPG = 6'd2;
    localparam logic [CW-1:0] EC_IFPG = 6'd3;
    localparam logic [CW-1:0] EC_MODP = 6'd4;
    localparam logic [CW-1:0] EC_NORD = 6'd5;
    localparam logic [CW-1:0] EC_NOEX = 6'd6;
    localparam logic [CW-1:0] EC_PRIV = 6'd7;
    localparam logic [CW-1:0] EC_ADRF = 6'd8;
    localparam logic [CW-1:0] EC_ADRM = 6'd9;
    localparam logic [CW-1:0] EC_DBRK = 6'd10;
    localparam logic [CW-1:0] EC_SYSC = 6'd11;
    localparam logic [CW-1:0] EC_BRKP = 6'd12;
    localparam logic [CW-1:0] EC_ILL  = 6'd13;
    localparam logic [CW-1:0] EC_IPRV = 6'd14;
    localparam logic [CW-1:0] EC_FPX  = 6'd15;
    localparam logic [CW-1:0] EC_BND  = 6'd16;

    localparam logic [CW-1:0] DBG_BKPT_CODE = 6'hC;

    typedef enum logic [1:0] {
        PATH_NORM   = 2'd0,
        PATH_REFILL = 2'd1,
        PATH_DEBUG  = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ENTERED = 2'd1,
        ST_FAULT   = 2'd2
    } state_e;

    typedef struct packed {
        logic          ok;
        path_e         path;
        logic          is_irq;
        logic          set_badv;
        logic          set_badi;
        logic [CW-1:0] cause;
    } decode_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [CW-1:0] code,
    input  logic          bus_fail,
    input  logic          bus_fetch,
    input  logic          refill,
    input  logic          cur_dst,
    output decode_t       dec
);
    logic [CW-1:0] eff;

    always_comb begin
        eff = bus_fail ? (bus_fetch ? EC_ADRF : EC_ADRM) : code;

        dec          = '0;
        dec.cause    = eff;
        dec.ok       = 1'b1;
        dec.set_badi = 1'b1;
        dec.path     = refill ? PATH_REFILL : PATH_NORM;

        case (eff)
            EC_INT: begin
                dec.is_irq   = 1'b1;
                dec.set_badi = 1'b0;
                if (cur_dst) dec.path = PATH_DEBUG;
            end
            EC_IFPG: dec.set_badi = 1'b0;
            EC_DBRK: dec.path = PATH_DEBUG;
            EC_SYSC, EC_BRKP, EC_ILL, EC_IPRV, EC_FPX, EC_BND:
                dec.set_badv = 1'b1;
            EC_LDPG, EC_STPG, EC_MODP, EC_NORD, EC_NOEX, EC_PRIV,
            EC_ADRF, EC_ADRM: ;
            default: begin
                dec.ok       = 1'b0;
                dec.set_badi = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             VW       = 4,
    parameter int             EXT_BASE = 64,
    parameter logic [AW-1:0]  DBG_OFS  = 'h480
) (
    input  decode_t       dec,
    input  logic [VW-1:0] vec_idx,
    input  logic [2:0]    vs,
    input  logic [AW-1:0] eentry,
    input  logic [AW-1:0] tlbrentry,
    output logic [AW-1:0] target
);
    localparam int IXW = $clog2(EXT_BASE + (1 << VW)) + 1;

    logic [IXW-1:0] slot;
    logic [AW-1:0]  offset;
    logic [3:0]     shamt;

    always_comb begin
        slot   = dec.is_irq ? IXW'(EXT_BASE) + IXW'(vec_idx) : IXW'(dec.cause);
        shamt  = {1'b0, vs} + 4'd2;
        offset = (vs == 3'd0) ? '0 : (AW'(slot) << shamt);
        case (dec.path)
            PATH_DEBUG:  target = eentry + DBG_OFS;
            PATH_REFILL: target = dec.is_irq ? eentry + offset : tlbrentry;
            default:     target = eentry + offset;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int             AW       = 32,
    parameter int             IW       = 32,
    parameter int             VW       = 4,
    parameter int             EXT_BASE = 64,
    parameter logic [AW-1:0]  RESET_PC = 'h1C00_0000,
    parameter logic [AW-1:0]  DBG_OFS  = 'h480
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [5:0]    code,
    input  logic          bus_fail,
    input  logic          bus_fetch,
    input  logic          refill,
    input  logic [VW-1:0] vec_idx,
    input  logic [AW-1:0] cur_pc,
    input  logic [IW-1:0] cur_insn,
    input  logic [1:0]    cur_plv,
    input  logic          cur_ie,
    input  logic          cur_dst,
    input  logic [AW-1:0] eentry,
    input  logic [AW-1:0] tlbrentry,
    input  logic [2:0]    vs,
    output logic [AW-1:0] pc_out,
    output logic          done,
    output logic          err,
    output logic [1:0]    mode_plv,
    output logic          mode_ie,
    output logic          mode_da,
    output logic          mode_pg,
    output logic [1:0]    mode_datf,
    output logic [1:0]    mode_datm,
    output logic [1:0]    prev_plv,
    output logic          prev_ie,
    output logic [AW-1:0] ret_addr,
    output logic [5:0]    ecode,
    output logic [AW-1:0] badv,
    output logic [IW-1:0] badi,
    output logic [1:0]    rf_prev_plv,
    output logic          rf_prev_ie,
    output logic [AW-3:0] rf_ret,
    output logic          dbg_flag,
    output logic          dbg_bkpt,
    output logic          dbg_intr,
    output logic [5:0]    dbg_code,
    output logic [AW-1:0] dbg_ret
);
    localparam logic [1:0] MTYPE_RST = 2'b01;

    decode_t       dec;
    logic [AW-1:0] target;
    logic          accept;
    logic          reject;
    state_e        state_q;
    state_e        state_d;

    exc_classify u_cls (
        .code      (code),
        .bus_fail  (bus_fail),
        .bus_fetch (bus_fetch),
        .refill    (refill),
        .cur_dst   (cur_dst),
        .dec       (dec)
    );

    exc_target #(
        .AW       (AW),
        .VW       (VW),
        .EXT_BASE (EXT_BASE),
        .DBG_OFS  (DBG_OFS)
    ) u_tgt (
        .dec       (dec),
        .vec_idx   (vec_idx),
        .vs        (vs),
        .eentry    (eentry),
        .tlbrentry (tlbrentry),
        .target    (target)
    );

    assign accept = take && dec.ok;
    assign reject = take && !dec.ok;

    // controller: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ENTERED, ST_FAULT: begin
                if (accept)      state_d = ST_ENTERED;
                else if (reject) state_d = ST_FAULT;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // controller: outputs
    always_comb begin
        done = 1'b0;
        err  = 1'b0;
        unique case (state_q)
            ST_ENTERED: done = 1'b1;
            ST_FAULT:   err  = 1'b1;
            default:    ;
        endcase
    end

    assign mode_datf = MTYPE_RST;
    assign mode_datm = MTYPE_RST;

    // architectural state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out      <= RESET_PC;
            mode_plv    <= 2'd0;
            mode_ie     <= 1'b0;
            mode_da     <= 1'b1;
            mode_pg     <= 1'b0;
            prev_plv    <= 2'd0;
            prev_ie     <= 1'b0;
            ret_addr    <= '0;
            ecode       <= '0;
            badv        <= '0;
            badi        <= '0;
            rf_prev_plv <= 2'd0;
            rf_prev_ie  <= 1'b0;
            rf_ret      <= '0;
            dbg_flag    <= 1'b0;
            dbg_bkpt    <= 1'b0;
            dbg_intr    <= 1'b0;
            dbg_code    <= '0;
            dbg_ret     <= '0;
        end else if (accept) begin
            pc_out   <= target;
            mode_plv <= 2'd0;
            mode_ie  <= 1'b0;
            case (dec.path)
                PATH_REFILL: begin
                    rf_prev_plv <= cur_plv;
                    rf_prev_ie  <= cur_ie;
                    mode_da     <= 1'b1;
                    mode_pg     <= 1'b0;
                    rf_ret      <= cur_pc[AW-1:2];
                end
                PATH_DEBUG: begin
                    dbg_ret  <= cur_pc;
                    dbg_flag <= 1'b1;
                    if (dec.is_irq) begin
                        dbg_intr <= 1'b1;
                    end else begin
                        dbg_bkpt <= 1'b1;
                        dbg_code <= DBG_BKPT_CODE;
                    end
                end
                default: begin
                    prev_plv <= cur_plv;
                    prev_ie  <= cur_ie;
                    ret_addr <= cur_pc;
                    ecode    <= dec.cause;
                end
            endcase
            if (dec.set_badv) badv <= cur_pc;
            if (dec.set_badi) badi <= cur_insn;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int             AW      = 32,
    parameter logic [AW-1:0]  DBG_OFS = 'h480
) (
    input logic          clk,
    input logic          rst_n,
    input logic          take,
    input logic [5:0]    code,
    input logic          bus_fail,
    input logic          refill,
    input logic [AW-1:0] cur_pc,
    input logic [AW-1:0] eentry,
    input logic [AW-1:0] tlbrentry,
    input logic [AW-1:0] pc_out,
    input logic          done,
    input logic          err,
    input logic [1:0]    mode_plv,
    input logic          mode_ie,
    input logic          mode_da,
    input logic          mode_pg,
    input logic [AW-1:0] ret_addr,
    input logic [5:0]    ecode,
    input logic [31:0]   badi,
    input logic          dbg_flag,
    input logic [5:0]    dbg_code
);
    // R2
    entry_masks_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_plv == 2'd0) && !mode_ie);

    // R2
    done_follows_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(take));

    // R12
    reject_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done && $stable(pc_out) && $stable(ret_addr) && $stable(ecode));

    // R3
    normal_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(take && !refill && !bus_fail && code == 6'd11)
        |-> ret_addr == $past(cur_pc) && ecode == 6'd11);

    // R4
    refill_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(take && refill && !bus_fail && code == 6'd1)
        |-> mode_da && !mode_pg && pc_out == $past(tlbrentry));

    // R7
    breakpoint_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(take && !bus_fail && code == 6'd10)
        |-> pc_out == $past(eentry) + DBG_OFS && dbg_flag && dbg_code == 6'hC);

    // R10
    irq_keeps_badi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(take && !bus_fail && code == 6'd0) |-> $stable(badi));
endmodule

bind exc_entry_seq exc_entry_chk #(.AW(AW), .DBG_OFS(DBG_OFS)) u_chk (.*);

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
    typedef struct packed {
        logic [5:0]  code;
        logic        bf;
        logic        bfetch;
        logic        rf;
        logic        dst;
        logic [2:0]  vs;
        logic [3:0]  vec;
        logic [31:0] exp_pc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{6'd11, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 4'd0,  32'h9000_0058},
        '{6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 4'd3,  32'h9000_0430},
        '{6'd1,  1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 4'd0,  32'h8000_1000},
        '{6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0,  32'h9000_0000},
        '{6'd50, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 4'd0,  32'h9000_0040},
        '{6'd11, 1'b1, 1'b0, 1'b0, 1'b0, 3'd7, 4'd0,  32'h9000_1200},
        '{6'd16, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 4'd0,  32'h9000_0400},
        '{6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 4'd15, 32'h9000_9E00},
        '{6'd10, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 4'd0,  32'h9000_0480},
        '{6'd0,  1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 4'd5,  32'h9000_0480}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take = 1'b0;
    logic [5:0]  code = '0;
    logic        bus_fail = 1'b0, bus_fetch = 1'b0, refill = 1'b0;
    logic [3:0]  vec_idx = '0;
    logic [31:0] cur_pc = '0, cur_insn = '0;
    logic [1:0]  cur_plv = '0;
    logic        cur_ie = 1'b0, cur_dst = 1'b0;
    logic [31:0] eentry = 32'h9000_0000, tlbrentry = 32'h8000_1000;
    logic [2:0]  vs = '0;
    logic [31:0] pc_out, ret_addr, badv, badi, dbg_ret;
    logic        done, err, mode_ie, mode_da, mode_pg, prev_ie, rf_prev_ie;
    logic        dbg_flag, dbg_bkpt, dbg_intr;
    logic [1:0]  mode_plv, mode_datf, mode_datm, prev_plv, rf_prev_plv;
    logic [5:0]  ecode, dbg_code;
    logic [29:0] rf_ret;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    exc_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .take(take), .code(code), .bus_fail(bus_fail),
        .bus_fetch(bus_fetch), .refill(refill), .vec_idx(vec_idx), .cur_pc(cur_pc),
        .cur_insn(cur_insn), .cur_plv(cur_plv), .cur_ie(cur_ie), .cur_dst(cur_dst),
        .eentry(eentry), .tlbrentry(tlbrentry), .vs(vs), .pc_out(pc_out),
        .done(done), .err(err), .mode_plv(mode_plv), .mode_ie(mode_ie),
        .mode_da(mode_da), .mode_pg(mode_pg), .mode_datf(mode_datf),
        .mode_datm(mode_datm), .prev_plv(prev_plv), .prev_ie(prev_ie),
        .ret_addr(ret_addr), .ecode(ecode), .badv(badv), .badi(badi),
        .rf_prev_plv(rf_prev_plv), .rf_prev_ie(rf_prev_ie), .rf_ret(rf_ret),
        .dbg_flag(dbg_flag), .dbg_bkpt(dbg_bkpt), .dbg_intr(dbg_intr),
        .dbg_code(dbg_code), .dbg_ret(dbg_ret)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pc", pc_out, 64'h1C00_0000);
        chk("R1 plv", mode_plv, 0);
        chk("R1 ie", mode_ie, 0);
        chk("R1 da", mode_da, 1);
        chk("R1 pg", mode_pg, 0);
        chk("R1 datf", mode_datf, 1);
        chk("R1 datm", mode_datm, 1);
        chk("R1 done/err", {done, err}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [5:0]  cause;
            logic        irq, dbg, rfp, wbadv, wbadi;
            logic [31:0] o_ret, o_badv, o_badi;
            logic [5:0]  o_ecode;
            cause = TBL[i].bf ? (TBL[i].bfetch ? 6'd8 : 6'd9) : TBL[i].code;
            irq   = (cause == 6'd0);
            dbg   = (cause == 6'd10) || (irq && TBL[i].dst);
            rfp   = TBL[i].rf && !dbg;
            wbadv = (cause >= 6'd11) && (cause <= 6'd16);
            wbadi = !irq && (cause != 6'd3);
            o_ret = ret_addr; o_badv = badv; o_badi = badi; o_ecode = ecode;

            code = TBL[i].code; bus_fail = TBL[i].bf; bus_fetch = TBL[i].bfetch;
            refill = TBL[i].rf; cur_dst = TBL[i].dst; vs = TBL[i].vs;
            vec_idx = TBL[i].vec;
            cur_pc = 32'h1000_0000 + 32'(i * 16);
            cur_insn = 32'hA500_0000 | 32'(i);
            cur_plv = 2'(i + 1);
            cur_ie = ~i[0];
            take = 1'b1;
            @(negedge clk);
            take = 1'b0;

            chk("R2 done", done, 1);
            chk("R2 plv", mode_plv, 0);
            chk("R2 ie", mode_ie, 0);
            // R5 R6 R7 R8 R11 target
            chk("R5/R6 target", pc_out, TBL[i].exp_pc);
            if (dbg) begin
                chk("R7 dbg_ret", dbg_ret, cur_pc);
                chk("R7 dbg_flag", dbg_flag, 1);
                if (irq) chk("R8 dbg_intr", dbg_intr, 1);
                else begin
                    chk("R7 dbg_bkpt", dbg_bkpt, 1);
                    chk("R7 dbg_code", dbg_code, 6'hC);
                end
                chk("R7 ret untouched", ret_addr, o_ret);
            end else if (rfp) begin
                chk("R4 rf_prev_plv", rf_prev_plv, cur_plv);
                chk("R4 rf_prev_ie", rf_prev_ie, cur_ie);
                chk("R4 rf_ret", rf_ret, cur_pc[31:2]);
                chk("R4 da/pg", {mode_da, mode_pg}, 2'b10);
                chk("R4 normal untouched", {ret_addr, ecode}, {o_ret, o_ecode});
            end else begin
                chk("R3 prev_plv", prev_plv, cur_plv);
                chk("R3 prev_ie", prev_ie, cur_ie);
                chk("R3 ret", ret_addr, cur_pc);
                chk(TBL[i].bf ? "R11 ecode" : "R3 ecode", ecode, cause);
            end
            chk("R9 badv", badv, wbadv ? cur_pc : o_badv);
            chk("R10 badi", badi, wbadi ? cur_insn : o_badi);
            @(negedge clk);
            chk("R2 pulse ends", done, 0);
        end

        // R12 unsupported cause
        begin
            logic [31:0] o_pc, o_ret, o_badi;
            o_pc = pc_out; o_ret = ret_addr; o_badi = badi;
            code = 6'd40; bus_fail = 1'b0; refill = 1'b0; cur_dst = 1'b0;
            cur_pc = 32'hDEAD_0000; cur_insn = 32'h1234_5678;
            take = 1'b1;
            @(negedge clk);
            take = 1'b0;
            chk("R12 err", err, 1);
            chk("R12 no done", done, 0);
            chk("R12 pc kept", pc_out, o_pc);
            chk("R12 ret kept", ret_addr, o_ret);
            chk("R12 badi kept", badi, o_badi);
            @(negedge clk);
            chk("R12 err pulse ends", err, 0);
        end

        // R1 reset again returns reset PC
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc after re-reset", pc_out, 64'h1C00_0000);
        chk("R1 dbg cleared", {dbg_flag, dbg_bkpt, dbg_intr}, 0);

        finished = 1'b1;
        summary();
    end
endmodule